// File: doc/BRIEF.md
# Master Clock Source Switcher

The block produces the master clock of a chip as an enable strobe in one fast system clock. Four candidate sources reach it as enable strobes in the same clock domain: the slow oscillator, the main oscillator and two PLL outputs. The block picks one of them, divides its strobe rate by a power of two, and reports through a ready flag whether the output has settled on the requested setting. Software writes an 8-bit configuration word and then polls the ready flag before it relies on the new clock.

A new setting is held as pending and is applied only when the divider has no partial period in progress. Once the switch has happened, ready returns after a short settling delay. The block also watches a lock input for each PLL. While the PLL that is currently selected reports no lock, the output runs from the slow source and ready stays low. When lock returns, the PLL source is restored and ready rises again after the same settling delay.

The configuration port is a plain write strobe with no back-pressure: every write is accepted in the cycle it is presented. A write that matches the setting already requested is dropped. The output strobe has no handshake and is consumed by whatever logic is clocked by the master clock enable.

Top module: `mclk_switch`

## Requirements
- R1: After reset the active source is slow (code 0), the active prescale code is 0, ready is 1, and `mck_en` equals `slow_en`.
- R2: Configuration bits [1:0] select the source: 0 slow, 1 main, 2 PLL A, 3 PLL B. With prescale code 0 and the source applied, `mck_en` equals that source's strobe in every cycle (0x01 gives main undivided).
- R3: Configuration bits [6:4] hold the prescale code n. For n from 0 to 6, `mck_en` pulses once for every 2^n strobes of the active source, in the same cycle as the 2^n-th strobe, and never in a cycle without a source strobe (0x11 gives main divided by 2).
- R4: Prescale code 7 is treated as division by 64.
- R5: A write whose source or prescale field differs from the setting already requested drives `mck_ready` low in the following cycle. Ready stays low until the new setting has been applied and has settled.
- R6: A pending setting is applied only in a cycle when the divider count is zero, so a period already under way completes under the old setting. The divider restarts from zero whenever a setting is applied.
- R7: `mck_ready` is 0 in the cycle where the new setting first shows on `act_src`/`act_pres` and in the cycle after it, and is 1 two cycles after that first cycle.
- R8: A write equal to the requested setting changes nothing: ready stays 1 and the active setting is unchanged. Bits 2, 3 and 7 of the word are ignored.
- R9: While the active source is PLL A (or PLL B) and its lock input is low, `act_src` reads 0, `mck_en` is driven by the slow strobe, and `mck_ready` is 0, starting in the same cycle that lock falls.
- R10: When that lock input returns high, `act_src` shows the PLL again in the same cycle. Ready is 0 in that cycle and in the next one, and is 1 two cycles after lock rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration word: source in [1:0], prescale in [6:4] |
| slow_en | input | 1 | Slow source enable strobe |
| main_en | input | 1 | Main source enable strobe |
| plla_en | input | 1 | PLL A enable strobe |
| pllb_en | input | 1 | PLL B enable strobe |
| plla_lock | input | 1 | PLL A lock indication |
| pllb_lock | input | 1 | PLL B lock indication |
| mck_en | output | 1 | Master clock enable strobe |
| mck_ready | output | 1 | Output has settled on the requested setting |
| act_src | output | 2 | Source currently driving the output (after any fallback) |
| act_pres | output | 3 | Prescale code currently applied |

## Verification
A setting is applied at the end of a divider period, and that period end can fall in the same cycle as a source strobe that closes the old period. This is provoked by moving to divide-by-64 on the slow source and then requesting the main source three strobes into a period. The bench counts the output pulses seen between the write and the switch; it expects exactly one, the closing pulse of the old period. Lock loss and lock return are each checked in the same cycle as their edge, against both the effective source and the ready flag.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

  localparam int SRC_W  = 2;
  localparam int PRES_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLLA = 2'd2,
    SRC_PLLB = 2'd3
  } src_e;

  typedef struct packed {
    src_e              src;
    logic [PRES_W-1:0] pres;
  } mclk_cfg_t;

  localparam mclk_cfg_t CFG_RESET = '{src: SRC_SLOW, pres: '0};

endpackage

// File: rtl/mclk_src_sel.sv
module mclk_src_sel
  import mclk_pkg::*;
#(
  parameter int N_PLL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             req_src,
  input  logic [3:0]       src_en,
  input  logic [N_PLL-1:0] pll_lock,
  output src_e             eff_src,
  output logic             sel_en,
  output logic             fallback
);

  localparam int PLL_BASE = 2;

  logic [N_PLL-1:0] pll_lost;

  generate
    for (genvar i = 0; i < N_PLL; i++) begin : g_pll
      localparam logic [SRC_W-1:0] PLL_CODE = SRC_W'(PLL_BASE + i);
      assign pll_lost[i] = (logic'(req_src == src_e'(PLL_CODE))) && !pll_lock[i];
    end
  endgenerate

  assign fallback = |pll_lost;
  assign eff_src  = fallback ? SRC_SLOW : req_src;
  assign sel_en   = src_en[eff_src];

  // R9
  fallback_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |-> (sel_en == src_en[0]));

  // R2
  locked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fallback |-> (sel_en == src_en[req_src]));

endmodule

// File: rtl/mclk_prescaler.sv
module mclk_prescaler
  import mclk_pkg::*;
#(
  parameter int MAX_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRES_W-1:0] pres,
  input  logic              tick_in,
  input  logic              restart,
  output logic              tick_out,
  output logic              cnt_zero
);

  localparam int CW = MAX_LOG2;

  logic [PRES_W-1:0] pres_eff;
  logic [CW:0]       span;
  logic [CW-1:0]     last;
  logic [CW-1:0]     cnt_q;

  assign pres_eff = (int'(pres) > MAX_LOG2) ? PRES_W'(MAX_LOG2) : pres;
  assign span     = (CW+1)'(1) << pres_eff;
  assign last     = CW'(span - (CW+1)'(1));
  assign tick_out = tick_in && (cnt_q == last);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (tick_in) begin
      if (cnt_q == last)     cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
    end
  end

  // R3
  out_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> tick_in);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_zero);

endmodule

// File: rtl/mclk_cfg_ctrl.sv
module mclk_cfg_ctrl
  import mclk_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int PRES_LSB   = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             cnt_zero,
  input  logic             fallback,
  output mclk_cfg_t        cur_cfg,
  output logic             restart,
  output logic             ready
);

  localparam int ST_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ST_W-1:0] ST_FULL = ST_W'(SETTLE_CYC);
  localparam logic [ST_W-1:0] ST_REL  = ST_W'(SETTLE_CYC - 1);

  mclk_cfg_t       cur_q, pend_q, wr_cfg, target;
  logic            pend_vld_q;
  logic            fb_q;
  logic [ST_W-1:0] settle_q;
  logic            wr_change;
  logic            apply;
  logic            unused_cfg_bits;

  assign wr_cfg.src  = src_e'(cfg_data[SRC_W-1:0]);
  assign wr_cfg.pres = cfg_data[PRES_LSB +: PRES_W];
  assign unused_cfg_bits = ^{cfg_data[PRES_LSB-1:SRC_W], cfg_data[CFG_W-1:PRES_LSB+PRES_W]};

  assign target    = pend_vld_q ? pend_q : cur_q;
  assign wr_change = cfg_we && (wr_cfg != target);
  assign apply     = pend_vld_q && cnt_zero;
  assign restart   = apply || (fallback != fb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= CFG_RESET;
      pend_q     <= CFG_RESET;
      pend_vld_q <= 1'b0;
    end else begin
      if (apply) cur_q <= pend_q;
      if (wr_change) begin
        pend_q     <= wr_cfg;
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      fb_q     <= 1'b0;
    end else begin
      fb_q <= fallback;
      if (apply)                  settle_q <= ST_FULL;
      else if (fb_q && !fallback) settle_q <= ST_REL;
      else if (settle_q != '0)    settle_q <= settle_q - ST_W'(1);
    end
  end

  assign cur_cfg = cur_q;
  assign ready   = !pend_vld_q && (settle_q == '0) && !fallback && !fb_q;

  // R5
  write_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_change |=> !ready);

  // R5
  ready_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !pend_vld_q);

  // R7
  settle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !ready);

  // R7
  settle_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> ##2 !ready);

  // R10
  relock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fallback) |-> !ready);

endmodule

// File: rtl/mclk_switch.sv
module mclk_switch
  import mclk_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int PRES_LSB   = 4,
  parameter int MAX_LOG2   = 6,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             slow_en,
  input  logic             main_en,
  input  logic             plla_en,
  input  logic             pllb_en,
  input  logic             plla_lock,
  input  logic             pllb_lock,
  output logic             mck_en,
  output logic             mck_ready,
  output logic [1:0]       act_src,
  output logic [2:0]       act_pres
);

  mclk_cfg_t cur_cfg;
  src_e      eff_src;
  logic      sel_en, fallback, restart, cnt_zero;

  mclk_cfg_ctrl #(
    .CFG_W(CFG_W), .PRES_LSB(PRES_LSB), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cnt_zero(cnt_zero), .fallback(fallback), .cur_cfg(cur_cfg),
    .restart(restart), .ready(mck_ready)
  );

  mclk_src_sel #(.N_PLL(2)) u_sel (
    .clk(clk), .rst_n(rst_n), .req_src(cur_cfg.src),
    .src_en({pllb_en, plla_en, main_en, slow_en}),
    .pll_lock({pllb_lock, plla_lock}),
    .eff_src(eff_src), .sel_en(sel_en), .fallback(fallback)
  );

  mclk_prescaler #(.MAX_LOG2(MAX_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .pres(cur_cfg.pres), .tick_in(sel_en),
    .restart(restart), .tick_out(mck_en), .cnt_zero(cnt_zero)
  );

  assign act_src  = eff_src;
  assign act_pres = cur_cfg.pres;

  // R6
  switch_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_pres) |-> $past(cnt_zero));

  // R9
  fallback_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |-> (!mck_ready && act_src == 2'd0));

endmodule

// File: tb/tb_mclk_switch.sv
module tb_mclk_switch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       slow_en = 1'b0, main_en = 1'b0, plla_en = 1'b0, pllb_en = 1'b0;
  logic       plla_lock = 1'b1, pllb_lock = 1'b1;
  logic       mck_en, mck_ready;
  logic [1:0] act_src;
  logic [2:0] act_pres;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  mclk_switch dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .slow_en(slow_en), .main_en(main_en), .plla_en(plla_en), .pllb_en(pllb_en),
    .plla_lock(plla_lock), .pllb_lock(pllb_lock),
    .mck_en(mck_en), .mck_ready(mck_ready), .act_src(act_src), .act_pres(act_pres)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    slow_en = (cyc % 8 == 0);
    main_en = (cyc % 2 == 0);
    plla_en = (cyc % 3 == 0);
    pllb_en = (cyc % 5 == 0);
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #2;
  endtask

  function automatic logic src_strobe(input int code);
    case (code)
      0: return slow_en;
      1: return main_en;
      2: return plla_en;
      default: return pllb_en;
    endcase
  endfunction

  // Writes v; samples the next cycle and checks ready dropped (R5).
  task automatic do_write(input logic [7:0] v, input bit expect_drop);
    @(negedge clk); cfg_we = 1'b1; cfg_data = v; #2;
    @(negedge clk); cfg_we = 1'b0; #2;
    if (expect_drop) chk(mck_ready == 1'b0, "R5 ready drop", mck_ready, 0);
  endtask

  // Waits for the new setting to appear, checks settle timing (R7), returns pulses seen first.
  task automatic wait_switch(input int s, input int p, output int pulses);
    int n = 0;
    pulses = 0;
    while ((act_src != 2'(s) || act_pres != 3'(p)) && n < 3000) begin
      if (mck_en) pulses++;
      tick(); n++;
    end
    chk(n < 3000, "R6 switch happened", n, 0);
    chk(mck_ready == 1'b0, "R7 ready low at switch", mck_ready, 0);
    tick();
    chk(mck_ready == 1'b0, "R7 ready low one after", mck_ready, 0);
    tick();
    chk(mck_ready == 1'b1, "R7 ready high two after", mck_ready, 1);
  endtask

  task automatic follow(input int code, input int len, input string tag);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      if (mck_en != src_strobe(code)) bad++;
      tick();
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic measure(input int code, input int ratio, input string tag);
    int n = 0, guard = 0, stray = 0;
    while (!mck_en && guard < 2000) begin tick(); guard++; end
    tick();
    while (guard < 4000) begin
      if (mck_en && !src_strobe(code)) stray++;
      if (src_strobe(code)) n++;
      if (mck_en) break;
      tick(); guard++;
    end
    chk(n == ratio, tag, n, ratio);
    chk(stray == 0, "R3 pulse only with strobe", stray, 0);
  endtask

  task automatic t_reset();
    chk(act_src == 2'd0, "R1 reset source", act_src, 0);
    chk(act_pres == 3'd0, "R1 reset prescale", act_pres, 0);
    chk(mck_ready == 1'b1, "R1 reset ready", mck_ready, 1);
    follow(0, 24, "R1 output follows slow");
  endtask

  task automatic t_main();
    int p;
    do_write(8'h01, 1'b1);
    wait_switch(1, 0, p);
    follow(1, 20, "R2 output follows main");
  endtask

  task automatic t_ignored();
    do_write(8'h8D, 1'b0);
    chk(mck_ready == 1'b1, "R8 ready kept", mck_ready, 1);
    for (int i = 0; i < 4; i++) tick();
    chk(mck_ready == 1'b1 && act_src == 2'd1 && act_pres == 3'd0,
        "R8 setting unchanged", {act_src, act_pres}, 8);
  endtask

  task automatic t_divide();
    int p;
    do_write(8'h11, 1'b1);
    wait_switch(1, 1, p);
    measure(1, 2, "R3 main div 2");
    do_write(8'h32, 1'b1);
    wait_switch(2, 3, p);
    measure(2, 8, "R3 plla div 8");
    do_write(8'h03, 1'b1);
    wait_switch(3, 0, p);
    follow(3, 20, "R2 output follows pllb");
    do_write(8'h71, 1'b1);
    wait_switch(1, 7, p);
    measure(1, 64, "R4 code 7 divides by 64");
  endtask

  task automatic t_boundary();
    int p, k = 0;
    do_write(8'h60, 1'b1);
    wait_switch(0, 6, p);
    while (!mck_en) tick();
    tick();
    while (k < 3) begin
      if (slow_en) k++;
      tick();
    end
    do_write(8'h01, 1'b1);
    wait_switch(1, 0, p);
    chk(p == 1, "R6 old period completes first", p, 1);
  endtask

  task automatic t_lock();
    int p;
    do_write(8'h02, 1'b1);
    wait_switch(2, 0, p);
    @(negedge clk); plla_lock = 1'b0; #2;
    chk(act_src == 2'd0, "R9 fallback source", act_src, 0);
    chk(mck_ready == 1'b0, "R9 ready low", mck_ready, 0);
    follow(0, 24, "R9 output follows slow");
    @(negedge clk); plla_lock = 1'b1; #2;
    chk(act_src == 2'd2, "R10 source restored", act_src, 2);
    chk(mck_ready == 1'b0, "R10 ready low at relock", mck_ready, 0);
    tick();
    chk(mck_ready == 1'b0, "R10 ready low one after", mck_ready, 0);
    tick();
    chk(mck_ready == 1'b1, "R10 ready high two after", mck_ready, 1);
    follow(2, 12, "R10 output follows plla");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_main();
    t_ignored();
    t_divide();
    t_boundary();
    t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule